// File: doc/BRIEF.md
# Interleaved Hamming(7,4) Word Codec (16 to 35 bits)

This block converts a 16-bit data word into a 35-bit line frame, and converts a received frame back into a word. The encoder breaks the word into four nibbles and protects each one with a Hamming(7,4) code. It then sends the four codes column by column: position 1 of every code, then position 2, and so on. After each column of four bits it adds a marker bit. The marker is 1 only when the four bits of its column are all zero, so a long gap can never appear in the frame. The frame is meant to be sent most significant bit first. When it is sent that way, a burst of adjacent line errors spreads across different nibbles.

The decoder undoes the interleaving and corrects up to one flipped bit in each nibble code. It also reports two counts. The first is how many nibbles it corrected. The second is how many marker bits disagree with the column before them. A receiver can use this count to tell whether a frame is aligned. The encoder and decoder are independent channels, and each has its own valid/ready handshake and a one-stage output register. Each channel accepts one word per cycle while its downstream side is ready.

Top module: `hamming35_codec`

## Requirements
- R1: The nibble order inside a word is: bits [15:12], then [7:4], then [11:8], then [3:0]. Bits [15:8] count as the first byte.
- R2: Each nibble d (d[0] is the least significant bit) is coded into positions 1..7. Data bits d[0], d[1], d[2], d[3] sit at positions 3, 5, 6 and 7. The parity bit at position 1 is the XOR of positions 3, 5 and 7. The parity bit at position 2 is the XOR of positions 3, 6 and 7. The parity bit at position 4 is the XOR of positions 5, 6 and 7.
- R3: In the 35-bit frame, bit 34 comes first. The frame holds 7 groups of 5 bits. Group g carries position g+1 of the four nibble codes, in the nibble order of R1, followed by a marker bit.
- R4: A marker bit is 1 when the four bits just before it are all 0, and 0 otherwise. As a result, every group of the encoded frame contains at least one 1. For example, word 0x402E encodes to 01000 10000 00001 11010 01010 10010 00010.
- R5: When the decoder receives an uncorrupted frame, it returns the original word with a correction count of 0 and a marker-error count of 0.
- R6: When any nibble code has one bit flipped, the decoder still returns the original word. The correction count equals the number of nibbles that had a flip, from 0 to 4.
- R7: The marker-error count is the number of groups, from 0 to 7, whose received marker differs from the value that R4 gives for the four bits received before it.
- R8: A flipped marker bit changes neither the decoded word nor the correction count.
- R9: For each channel: a word accepted on a cycle (in-valid and in-ready both high) is presented on the output on the next cycle. The output holds stable while out-ready is low. In-ready is low only while a held output is waiting.
- R10: After reset, both output-valid signals are low and both in-ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encInValid | input | 1 | Encoder input word is valid |
| encInReady | output | 1 | Encoder can take a word |
| encInData | input | 16 | Word to encode |
| encOutValid | output | 1 | Encoded frame is valid |
| encOutReady | input | 1 | Consumer takes the encoded frame |
| encOutCode | output | 35 | Encoded frame, bit 34 sent first |
| decInValid | input | 1 | Decoder input frame is valid |
| decInReady | output | 1 | Decoder can take a frame |
| decInCode | input | 35 | Received frame, bit 34 first |
| decOutValid | output | 1 | Decoded result is valid |
| decOutReady | input | 1 | Consumer takes the decoded result |
| decOutData | output | 16 | Recovered word |
| decOutStopErr | output | 3 | Number of inconsistent marker bits |
| decOutCorr | output | 3 | Number of corrected nibbles |

## Verification
Every coding path in this block is combinational into a single output register. A wrong parity equation, a wrong interleave index or a wrong nibble slot therefore shows up on the output one cycle after the word that uses it. The bench runs every one of the 65536 words through both channels, so any such fault appears within that sweep. Faults in the correction and counting paths only show up on corrupted frames. For that reason, every single-bit flip in every nibble code, and every marker flip, is applied to a spread of words, and the two counts are compared with a nearest-codeword model. A handshake fault shows up as an output that changes or a word that is lost during a stall. Both are checked on the cycle of the stall.

// File: rtl/hamming35_pkg.sv
package hamming35_pkg;

  localparam int H35_NIB_W  = 4;
  localparam int H35_NIBS   = 4;
  localparam int H35_CW_W   = 7;
  localparam int H35_WORD_W = H35_NIB_W * H35_NIBS;
  localparam int H35_GRP_W  = H35_NIBS + 1;
  localparam int H35_FRAME_W = H35_CW_W * H35_GRP_W;
  localparam int H35_CNT_W  = $clog2(H35_CW_W + 1);

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } h35_strobe_t;

  typedef struct packed {
    logic [H35_NIB_W-1:0] data;
    logic                 fixed;
  } h35_fix_t;

  // Least significant bit of the nibble in slot idx (R1 order).
  function automatic int h35NibLsb(input int idx);
    int byteSel;
    int hiLo;
    byteSel = idx % 2;
    hiLo    = idx / 2;
    return H35_WORD_W - 8 * byteSel - H35_NIB_W - H35_NIB_W * hiLo;
  endfunction

  // Hamming(7,4); result bit 6 is position 1.
  function automatic logic [H35_CW_W-1:0] h35CodeNibble(input logic [H35_NIB_W-1:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {p1, p2, d[0], p4, d[1], d[2], d[3]};
  endfunction

  // Syndrome decode of one 7-bit code (bit 6 is position 1).
  function automatic h35_fix_t h35FixNibble(input logic [H35_CW_W-1:0] rx);
    logic [H35_CW_W-1:0] r;
    logic [2:0] syn;
    h35_fix_t res;
    r = rx;
    syn[0] = r[6] ^ r[4] ^ r[2] ^ r[0];
    syn[1] = r[5] ^ r[4] ^ r[1] ^ r[0];
    syn[2] = r[3] ^ r[2] ^ r[1] ^ r[0];
    if (syn != 3'd0) r[H35_CW_W - int'(syn)] = ~r[H35_CW_W - int'(syn)];
    res.data  = {r[0], r[1], r[2], r[4]};
    res.fixed = (syn != 3'd0);
    return res;
  endfunction

  // Full frame encode: column interleave plus marker per group.
  function automatic logic [H35_FRAME_W-1:0] h35Encode(input logic [H35_WORD_W-1:0] w);
    logic [H35_FRAME_W-1:0] f;
    logic [H35_CW_W-1:0] cw [H35_NIBS];
    logic [H35_NIBS-1:0] col;
    for (int k = 0; k < H35_NIBS; k++) cw[k] = h35CodeNibble(w[h35NibLsb(k) +: H35_NIB_W]);
    f = '0;
    for (int g = 0; g < H35_CW_W; g++) begin
      for (int k = 0; k < H35_NIBS; k++) begin
        col[k] = cw[k][H35_CW_W-1-g];
        f[H35_FRAME_W-1-(g*H35_GRP_W+k)] = col[k];
      end
      f[H35_FRAME_W-1-(g*H35_GRP_W+H35_NIBS)] = ~|col;
    end
    return f;
  endfunction

endpackage

// File: rtl/h35_ctrl.sv
module h35_ctrl
  import hamming35_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        encInValid,
  input  logic        encOutReady,
  input  logic        decInValid,
  input  logic        decOutReady,
  output logic        encInReady,
  output logic        encOutValid,
  output logic        decInReady,
  output logic        decOutValid,
  output h35_strobe_t strobe
);

  assign encInReady     = !encOutValid || encOutReady;
  assign decInReady     = !decOutValid || decOutReady;
  assign strobe.encLoad = encInValid && encInReady;
  assign strobe.decLoad = decInValid && decInReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      if (strobe.encLoad)   encOutValid <= 1'b1;
      else if (encOutReady) encOutValid <= 1'b0;
      if (strobe.decLoad)   decOutValid <= 1'b1;
      else if (decOutReady) decOutValid <= 1'b0;
    end
  end

endmodule

// File: rtl/h35_datapath.sv
module h35_datapath
  import hamming35_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  h35_strobe_t            strobe,
  input  logic [H35_WORD_W-1:0]  encInData,
  input  logic [H35_FRAME_W-1:0] decInCode,
  output logic [H35_FRAME_W-1:0] encOutCode,
  output logic [H35_WORD_W-1:0]  decOutData,
  output logic [H35_CNT_W-1:0]   decOutStopErr,
  output logic [H35_CNT_W-1:0]   decOutCorr
);

  logic [H35_FRAME_W-1:0] encNext;
  logic [H35_NIBS-1:0]    nibFixed;
  logic [H35_CW_W-1:0]    stopBad;
  logic [H35_WORD_W-1:0]  decWord;
  logic [H35_NIB_W-1:0]   nibData [H35_NIBS];

  assign encNext = h35Encode(encInData);

  // De-interleave and correct each nibble code.
  for (genvar k = 0; k < H35_NIBS; k++) begin : g_nib
    logic [H35_CW_W-1:0] rxCode;
    h35_fix_t            fixRes;
    for (genvar g = 0; g < H35_CW_W; g++) begin : g_pos
      assign rxCode[H35_CW_W-1-g] = decInCode[H35_FRAME_W-1-(g*H35_GRP_W+k)];
    end
    assign fixRes      = h35FixNibble(rxCode);
    assign nibData[k]  = fixRes.data;
    assign nibFixed[k] = fixRes.fixed;
  end

  // Marker consistency per group.
  for (genvar g = 0; g < H35_CW_W; g++) begin : g_grp
    logic [H35_GRP_W-1:0] grp;
    assign grp        = decInCode[H35_FRAME_W-1-g*H35_GRP_W -: H35_GRP_W];
    assign stopBad[g] = grp[0] != ~|grp[H35_GRP_W-1:1];
  end

  always_comb begin
    decWord = '0;
    for (int k = 0; k < H35_NIBS; k++) decWord[h35NibLsb(k) +: H35_NIB_W] = nibData[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encOutCode    <= '0;
      decOutData    <= '0;
      decOutStopErr <= '0;
      decOutCorr    <= '0;
    end else begin
      if (strobe.encLoad) encOutCode <= encNext;
      if (strobe.decLoad) begin
        decOutData    <= decWord;
        decOutStopErr <= H35_CNT_W'($countones(stopBad));
        decOutCorr    <= H35_CNT_W'($countones(nibFixed));
      end
    end
  end

endmodule

// File: rtl/hamming35_codec.sv
module hamming35_codec
  import hamming35_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        encInValid,
  output logic        encInReady,
  input  logic [15:0] encInData,
  output logic        encOutValid,
  input  logic        encOutReady,
  output logic [34:0] encOutCode,
  input  logic        decInValid,
  output logic        decInReady,
  input  logic [34:0] decInCode,
  output logic        decOutValid,
  input  logic        decOutReady,
  output logic [15:0] decOutData,
  output logic [2:0]  decOutStopErr,
  output logic [2:0]  decOutCorr
);

  h35_strobe_t strobe;

  h35_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .encInValid(encInValid), .encOutReady(encOutReady),
    .decInValid(decInValid), .decOutReady(decOutReady),
    .encInReady(encInReady), .encOutValid(encOutValid),
    .decInReady(decInReady), .decOutValid(decOutValid),
    .strobe(strobe)
  );

  h35_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .encInData(encInData), .decInCode(decInCode),
    .encOutCode(encOutCode), .decOutData(decOutData),
    .decOutStopErr(decOutStopErr), .decOutCorr(decOutCorr)
  );

endmodule

// File: rtl/h35_checker.sv
module h35_checker (
  input logic        clk,
  input logic        rstN,
  input logic        encInValid,
  input logic        encInReady,
  input logic        encOutValid,
  input logic        encOutReady,
  input logic [34:0] encOutCode,
  input logic        decInValid,
  input logic        decInReady,
  input logic        decOutValid,
  input logic        decOutReady,
  input logic [15:0] decOutData,
  input logic [2:0]  decOutStopErr,
  input logic [2:0]  decOutCorr
);

  function automatic logic allGroupsLive(input logic [34:0] f);
    logic ok;
    ok = 1'b1;
    for (int g = 0; g < 7; g++) ok = ok & (|f[34-5*g -: 5]);
    return ok;
  endfunction

  AST_ENC_GROUP_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid |-> allGroupsLive(encOutCode)); // R4

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    encInValid && encInReady |=> encOutValid); // R9

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    decInValid && decInReady |=> decOutValid); // R9

  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid && !encOutReady |=> encOutValid && $stable(encOutCode)); // R9

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid && !decOutReady |=> decOutValid && $stable(decOutData)
      && $stable(decOutStopErr) && $stable(decOutCorr)); // R9

  AST_ENC_READY_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !encOutValid |-> encInReady); // R10

  AST_DEC_CORR_MAX: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid |-> decOutCorr <= 3'd4); // R6

endmodule

bind hamming35_codec h35_checker chk_i (
  .clk(clk), .rstN(rstN),
  .encInValid(encInValid), .encInReady(encInReady),
  .encOutValid(encOutValid), .encOutReady(encOutReady), .encOutCode(encOutCode),
  .decInValid(decInValid), .decInReady(decInReady),
  .decOutValid(decOutValid), .decOutReady(decOutReady), .decOutData(decOutData),
  .decOutStopErr(decOutStopErr), .decOutCorr(decOutCorr)
);

// File: tb/hamming35_codec_tb.sv
`timescale 1ns/1ps
module hamming35_codec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encInValid = 1'b0;
  logic        encInReady;
  logic [15:0] encInData = '0;
  logic        encOutValid;
  logic        encOutReady = 1'b1;
  logic [34:0] encOutCode;
  logic        decInValid = 1'b0;
  logic        decInReady;
  logic [34:0] decInCode = '0;
  logic        decOutValid;
  logic        decOutReady = 1'b1;
  logic [15:0] decOutData;
  logic [2:0]  decOutStopErr;
  logic [2:0]  decOutCorr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  hamming35_codec dut_i (.*);

  // {word, frame}: R1..R4 known vectors
  localparam logic [50:0] VEC [0:2] = '{
    {16'h402E, 35'b01000_10000_00001_11010_01010_10010_00010},
    {16'h0000, 35'b00001_00001_00001_00001_00001_00001_00001},
    {16'hFFFF, 35'b11110_11110_11110_11110_11110_11110_11110}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: parity by position-set membership
  function automatic logic [6:0] refCw(input logic [3:0] n);
    logic [7:1] pos;
    logic [6:0] cw;
    pos = '0;
    pos[3] = n[0]; pos[5] = n[1]; pos[6] = n[2]; pos[7] = n[3];
    for (int j = 0; j < 3; j++) begin
      logic par;
      par = 1'b0;
      for (int p = 3; p <= 7; p++) if (p != 4 && (p & (1 << j)) != 0) par ^= pos[p];
      pos[1 << j] = par;
    end
    for (int p = 1; p <= 7; p++) cw[7 - p] = pos[p];
    return cw;
  endfunction

  function automatic logic [3:0] refNib(input logic [15:0] w, input int k);
    case (k)
      0: return w[15:12];
      1: return w[7:4];
      2: return w[11:8];
      default: return w[3:0];
    endcase
  endfunction

  function automatic logic [34:0] refEnc(input logic [15:0] w);
    logic [34:0] f;
    int s;
    s = 0;
    for (int g = 0; g < 7; g++) begin
      logic anyOne;
      anyOne = 1'b0;
      for (int k = 0; k < 4; k++) begin
        logic b;
        b = refCw(refNib(w, k))[6 - g];
        anyOne |= b;
        f[34 - s] = b; s++;
      end
      f[34 - s] = !anyOne; s++;
    end
    return f;
  endfunction

  function automatic int refStopErr(input logic [34:0] f);
    int n;
    n = 0;
    for (int g = 0; g < 7; g++) begin
      logic [4:0] grp;
      grp = f[34 - 5*g -: 5];
      if (grp[0] != (grp[4:1] == 4'b0000)) n++;
    end
    return n;
  endfunction

  function automatic logic [34:0] flipAt(input logic [34:0] f, input int g, input int k);
    logic [34:0] r;
    r = f;
    r[34 - (g*5 + k)] = ~r[34 - (g*5 + k)];
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic decodeCheck(input logic [34:0] c, input logic [15:0] expW,
                             input int expCorr, input int expStop, input string req);
    decInCode = c; decInValid = 1'b1;
    step();
    chk(decOutValid == 1'b1, req, decOutValid, 1);
    chk(decOutData == expW, req, decOutData, expW);
    chk(int'(decOutCorr) == expCorr, req, decOutCorr, expCorr);
    chk(int'(decOutStopErr) == expStop, req, decOutStopErr, expStop);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(encOutValid == 1'b0, "R10 encOutValid", encOutValid, 0);
    chk(decOutValid == 1'b0, "R10 decOutValid", decOutValid, 0);
    chk(encInReady == 1'b1, "R10 encInReady", encInReady, 1);
    chk(decInReady == 1'b1, "R10 decInReady", decInReady, 1);
    rstN = 1'b1;
    step();

    // Known vectors R1 R2 R3 R4, and decode R5
    for (int i = 0; i < 3; i++) begin
      encInData = VEC[i][50:35]; encInValid = 1'b1;
      decInCode = VEC[i][34:0];  decInValid = 1'b1;
      step();
      chk(encOutCode == VEC[i][34:0], "R1 R2 R3 R4 vector", encOutCode, VEC[i][34:0]);
      chk(decOutData == VEC[i][50:35], "R5 vector", decOutData, VEC[i][50:35]);
    end

    // Exhaustive sweep: R2 R3 encode, R5 clean decode
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] w;
      logic [34:0] e;
      w = 16'(i);
      e = refEnc(w);
      encInData = w; encInValid = 1'b1;
      decInCode = e; decInValid = 1'b1;
      step();
      chk(encOutCode == e, "R3 sweep encode", encOutCode, e);
      chk(decOutData == w && decOutCorr == 3'd0 && decOutStopErr == 3'd0,
          "R5 sweep decode", {decOutData, decOutCorr, decOutStopErr}, {w, 6'd0});
    end
    encInValid = 1'b0;

    // R6 R7: every single flip inside every nibble code
    for (int t = 0; t < 64; t++) begin
      logic [15:0] w;
      logic [34:0] e;
      w = 16'(t * 1031) ^ 16'h5A3C;
      e = refEnc(w);
      for (int k = 0; k < 4; k++)
        for (int g = 0; g < 7; g++) begin
          logic [34:0] c;
          c = flipAt(e, g, k);
          decodeCheck(c, w, 1, refStopErr(c), "R6 R7 single flip");
        end
      // R8: marker flips
      for (int g = 0; g < 7; g++) decodeCheck(flipAt(e, g, 4), w, 0, 1, "R8 marker flip");
    end

    // R6: one flip in each of the four nibbles
    begin
      logic [34:0] c;
      c = refEnc(16'hC0DE);
      for (int k = 0; k < 4; k++) c = flipAt(c, k, k);
      decodeCheck(c, 16'hC0DE, 4, refStopErr(c), "R6 four nibbles");
    end
    // R7 R8: all markers flipped
    begin
      logic [34:0] c;
      c = refEnc(16'h1234);
      for (int g = 0; g < 7; g++) c = flipAt(c, g, 4);
      decodeCheck(c, 16'h1234, 0, 7, "R7 R8 all markers");
    end
    decInValid = 1'b0;
    step();

    // R9: encoder stall
    encOutReady = 1'b0;
    encInData = 16'hA5A5; encInValid = 1'b1;
    step();
    chk(encOutValid == 1'b1 && encOutCode == refEnc(16'hA5A5), "R9 load", encOutCode, refEnc(16'hA5A5));
    encInData = 16'h0F0F;
    chk(encInReady == 1'b0, "R9 ready low when held", encInReady, 0);
    step();
    chk(encOutCode == refEnc(16'hA5A5), "R9 hold", encOutCode, refEnc(16'hA5A5));
    encOutReady = 1'b1;
    step();
    chk(encOutCode == refEnc(16'h0F0F), "R9 next after stall", encOutCode, refEnc(16'h0F0F));
    encInValid = 1'b0;
    step();
    chk(encOutValid == 1'b0, "R9 drain", encOutValid, 0);

    // R9: decoder stall
    decOutReady = 1'b0;
    decInCode = refEnc(16'hBEEF); decInValid = 1'b1;
    step();
    decInCode = refEnc(16'h7777);
    chk(decInReady == 1'b0, "R9 dec ready low", decInReady, 0);
    step();
    chk(decOutData == 16'hBEEF, "R9 dec hold", decOutData, 16'hBEEF);
    decOutReady = 1'b1;
    step();
    chk(decOutData == 16'h7777, "R9 dec next", decOutData, 16'h7777);
    decInValid = 1'b0;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule